// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Detector

This block watches a serial bit stream, taking one bit `w` per rising clock edge. It raises `z` while the three most recent bits taken since reset read 1,1,0 or 0,1,0, oldest first. Both targets end in "1 then 0", so one merged Moore state graph tracks them both. That graph only has to know whether the trailing 1 had a bit before it. Matches may overlap: the last bits of one match can begin the next.

`z` is decoded from the state register alone. It therefore shows a match in the clock cycle after the edge that took the third bit. A synchronous active-low reset returns the machine to a start state that holds no history. Reset can be applied in mid-stream to drop everything seen so far.

Top module: `seqdet_dual`

## Requirements
- R1: A rising edge with `rst_n` low puts the machine in its start state whatever `w` is, and `z` reads 0 in the following cycle. The state register only ever holds one of its five legal codes, and any other code returns to the start state.
- R2: When the last three bits taken are 1,1,0 (oldest first), `z` is 1 in the cycle after the edge that took the final 0.
- R3: When the last three bits taken are 0,1,0 (oldest first), `z` is 1 in the cycle after the edge that took the final 0.
- R4: For every other three-bit window (000, 001, 011, 100, 101, 111), `z` is 0 in that cycle.
- R5: `z` stays 0 until at least three bits have been taken since reset, even when the first two bits are 1 then 0.
- R6: Overlapping matches are all reported. The stream 0,1,0,1,0 gives `z` after the third and the fifth bit, and a 1,1,0 followed by 1,0 reports twice.
- R7: A reset in mid-stream discards the history. A 1 taken before reset does not combine with 1,0 taken after it.
- R8: For the stream 0 1 0 0 1 1 0 1 0 1 1 1 0 1 1 taken after reset, `z` is 1 after bits 3, 7, 9 and 13 and 0 after all others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change occurs on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| w | input | 1 | Serial data bit, taken on each rising edge |
| z | output | 1 | Match flag, decoded from the present state only |

## Verification
The assertions check several properties on every cycle. A reset edge must leave the start state with `z` low. The state code must stay legal. A raised `z` must always be backed by a 1 then a 0 on the two previous samples, with at least three samples since reset. A completed "1 then 0" after two or more samples must raise `z`, and a match followed by 1,0 must fire again. Other behaviour needs concrete streams from the bench, compared against a three-bit reference window: that the third-oldest bit really is a don't-care, the exact count and position of hits in the given trace, history being dropped by a mid-stream reset, and long random streams.

// File: rtl/seqdet_pkg.sv
// Package: seqdet_pkg
// Shared state codes for the dual-pattern detector.
// Assumes a binary encoding in one register; codes above ST_HIT are unused.
package seqdet_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,  // nothing taken since reset
        ST_ONE  = 3'd1,  // exactly one bit taken, value irrelevant
        ST_RISE = 3'd2,  // last bit 1 and it had a predecessor
        ST_LOW  = 3'd3,  // last bit 0, window is not a match
        ST_HIT  = 3'd4   // last three bits are x,1,0
    } seq_state_t;

    localparam logic [STATE_W-1:0] ST_LAST_LEGAL = ST_HIT;
endpackage

// File: rtl/seqdet_next.sv
// Module: seqdet_next
// Pure next-state logic of the merged detector graph.
// Assumes cur_st comes from the state register; illegal codes go to ST_IDLE.
module seqdet_next
    import seqdet_pkg::*;
(
    input  logic [STATE_W-1:0] cur_st,
    input  logic               bit_in,
    output logic [STATE_W-1:0] nxt_st
);
    // Transition table: after a hit, a 1 continues toward ST_RISE and a 0 goes to ST_LOW.
    always_comb begin
        case (cur_st)
            ST_IDLE: nxt_st = ST_ONE;
            ST_ONE:  nxt_st = bit_in ? ST_RISE : ST_LOW;
            ST_RISE: nxt_st = bit_in ? ST_RISE : ST_HIT;
            ST_LOW:  nxt_st = bit_in ? ST_RISE : ST_LOW;
            ST_HIT:  nxt_st = bit_in ? ST_RISE : ST_LOW;
            default: nxt_st = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/seqdet_state_reg.sv
// Module: seqdet_state_reg
// Holds the binary state code with synchronous active-low reset.
// Assumes rst_n is synchronous to clk.
module seqdet_state_reg #(
    parameter int              W         = 3,
    parameter logic [W-1:0]    RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // State capture: load reset code or next state on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/seqdet_out.sv
// Module: seqdet_out
// Moore output decode: the flag depends on the present state only.
// Assumes the hit state is the single state that signals a match.
module seqdet_out
    import seqdet_pkg::*;
(
    input  logic [STATE_W-1:0] cur_st,
    output logic               hit
);
    // Output decode: raise the flag only in the hit state.
    always_comb hit = (cur_st == ST_HIT);
endmodule

// File: rtl/seqdet_dual.sv
// Module: seqdet_dual
// Top of the detector for the windows 1,1,0 and 0,1,0 with overlap.
// Assumes one bit of w per rising edge and a synchronous active-low reset.
module seqdet_dual
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic w,
    output logic z
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;

    seqdet_next u_next (
        .cur_st (state_q),
        .bit_in (w),
        .nxt_st (state_d)
    );

    seqdet_state_reg #(
        .W         (STATE_W),
        .RESET_VAL (ST_IDLE)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (state_d),
        .q     (state_q)
    );

    seqdet_out u_out (
        .cur_st (state_q),
        .hit    (z)
    );

    // Checking support: counts samples since reset, saturating at three.
    logic [1:0] seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              seen_q <= 2'd0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!z && state_q == ST_IDLE)); // R1

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= ST_LAST_LEGAL); // R1

    AST_HIT_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        z |-> (seen_q == 2'd3 && !$past(w) && $past(w, 2))); // R2

    AST_HIT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 2'd2 && $past(w) && !w) |=> z); // R3

    AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd3) |-> !z); // R5

    AST_OVERLAP_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(z) && $past(w) && !w) |=> z); // R6
endmodule

// File: tb/sim_seqdet_dual.sv
`timescale 1ns/1ps
// Bench: the driver task pushes the expected flag for each cycle into a queue;
// the monitor pops one entry after every rising edge and compares it with z.
module sim_seqdet_dual;
    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic w     = 1'b0;
    logic z;

    int errors = 0;
    int checks = 0;

    logic  exp_q[$];
    string tag_q[$];

    logic [2:0] ref_hist = 3'b000;
    int         ref_cnt  = 0;

    always #2 clk = ~clk;

    seqdet_dual u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .w     (w),
        .z     (z)
    );

    // Driver: applies one cycle of stimulus and queues the expected flag.
    task automatic step(input logic r, input logic b, input string tag);
        logic  e;
        string t;
        @(negedge clk);
        rst_n = r;
        w     = b;
        if (!r) begin
            ref_hist = 3'b000;
            ref_cnt  = 0;
            e = 1'b0;
            t = "R1";
        end else begin
            ref_hist = {ref_hist[1:0], b};
            if (ref_cnt < 3) ref_cnt++;
            e = (ref_cnt == 3) && (ref_hist[1:0] == 2'b10);
            if (tag != "")                t = tag;
            else if (ref_cnt < 3)         t = "R5";
            else if (ref_hist == 3'b110)  t = "R2";
            else if (ref_hist == 3'b010)  t = "R3";
            else                          t = "R4";
        end
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic bits(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) begin
            if (s[i] == "0")      step(1'b1, 1'b0, tag);
            else if (s[i] == "1") step(1'b1, 1'b1, tag);
        end
    endtask

    // Monitor: compares z with the queued expectation after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (z !== e) begin
                    errors++;
                    $display("FAIL %s: z=%b expected %b at %0t", t, z, e, $time);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset held with w toggling keeps z low
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R1");
        // R5: 1 then 0 right after reset must not fire; the third bit may
        bits("10", "R5");
        bits("0", "");
        step(1'b0, 1'b0, "R1");
        // R2, R3, R4: every three-bit window after a fresh reset
        for (int v = 0; v < 8; v++) begin
            step(1'b0, 1'b0, "R1");
            step(1'b1, v[2], "");
            step(1'b1, v[1], "");
            step(1'b1, v[0], "");
        end
        // R6: overlapping chains
        step(1'b0, 1'b0, "R1");
        bits("01010", "R6");
        bits("11010", "R6");
        // R7: a bit before a mid-stream reset must not join bits after it
        bits("1", "R7");
        step(1'b0, 1'b1, "R1");
        bits("10", "R7");
        bits("110", "R7");
        // R1: reset during a hit clears z next cycle
        bits("10", "");
        step(1'b0, 1'b0, "R1");
        // R8: the given trace; hits after bits 3, 7, 9, 13
        bits("010011010111011", "R8");
        // R2, R3, R4: long random stream
        step(1'b0, 1'b0, "R1");
        for (int i = 0; i < 3000; i++) step(1'b1, 1'($urandom % 2), "");
        @(posedge clk);
        #2;
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R1: queue left=%0d expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule